// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the 16-bit operand address or branch target for a small 8/16-bit processor. Decode hands it a mode code, the value of the general register that the instruction names, the extension word fetched with the instruction, the program counter and a byte/word size flag. In one cycle it returns the address, an updated register value with its write enable for the auto-stepping modes, and a flag for an address that breaks the even-alignment rule.

The memory-indirect mode needs a second step. The block reads one word from the bottom page over a request/valid port, and that word becomes the branch target. While that read is outstanding the block is busy and ignores new start pulses. All arithmetic wraps modulo 2^16 and no overflow is signalled.

Top module: `ea_gen`

## Requirements
- R1: Mode codes are 0 register indirect, 1 displacement, 2 post-increment, 3 pre-decrement, 4 short absolute, 5 long absolute, 6 PC-relative and 7 memory indirect. For every mode except 7, an accepted start gives done=1 in the same cycle. With mode 0 the address is the register value. With mode 1 it is the register value plus the 16-bit extension word. Neither mode writes back.
- R2: In mode 2 the address is the unchanged register value. The write-back value is the register plus 1 for a byte operand (word_sz=0) or plus 2 for a word operand (word_sz=1), and reg_we=1.
- R3: In mode 3 the register is first reduced by 1 (byte) or 2 (word). That reduced value is both the address and the write-back value, and reg_we=1.
- R4: In modes 2 and 3, a word operand with an odd original register value raises fault together with done, and reg_we stays 0.
- R5: Mode 4 forms the address as 0xFF followed by the low extension byte. Mode 5 uses the extension word unchanged. In modes 0, 1, 4 and 5, a word operand at an odd address raises fault.
- R6: Mode 6 adds the low extension byte, sign-extended, to the pc input (the next-instruction address). An odd target raises fault for either operand size.
- R7: In mode 7 with an even low extension byte, mem_req rises in the cycle after start and stays high through the cycle in which mem_valid is seen. mem_addr is 0x00 followed by that byte. mem_rdata carries the byte at the even address in bits 15:8. One cycle after mem_valid, done=1 and the address equals the word that was read, with fault=0.
- R8: In mode 7 with an odd pointer byte, fault and done rise in the start cycle and no read is requested.
- R9: Sums and differences wrap modulo 2^16. For example, 0xFFF0 plus 0x0020 gives 0x0010, and a byte pre-decrement of 0x0000 gives 0xFFFF.
- R10: While a memory-indirect read is in progress, and in its completion cycle, start is ignored. Only the completion itself raises done, and reg_we stays 0.
- R11: With no accepted start, done, fault and reg_we are 0. During and after reset, mem_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Compute request for one cycle |
| mode | input | 3 | Addressing mode code |
| word_sz | input | 1 | 1 = word operand, 0 = byte operand |
| reg_val | input | 16 | Value of the named general register |
| ext_word | input | 16 | Extension word; the 8-bit fields use bits 7:0 |
| pc | input | 16 | Address of the next instruction |
| mem_req | output | 1 | Word read request for memory indirect |
| mem_addr | output | 16 | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data, even-address byte in bits 15:8 |
| done | output | 1 | Result valid this cycle |
| ea | output | 16 | Effective address or branch target |
| fault | output | 1 | Alignment fault, valid with done |
| reg_we | output | 1 | Register write-back enable |
| reg_wdata | output | 16 | Register write-back value |

## Verification
The case that is hardest to reach from the ports is a start pulse that arrives while a memory-indirect read is outstanding. That start uses a mode which would otherwise complete at once and write back. To reach it, the bench holds back mem_valid for several cycles and drives such a start inside that window. The reference model then expects no done and no write enable until the fetched target emerges. The memory latency is varied from zero cycles upward, and odd pointers are mixed in to confirm that no request leaves the block.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned EA_AW = 16;
  localparam int unsigned EA_SW = 8;

  typedef enum logic [2:0] {
    EA_RIND    = 3'd0,
    EA_DISP    = 3'd1,
    EA_POSTINC = 3'd2,
    EA_PREDEC  = 3'd3,
    EA_ABS8    = 3'd4,
    EA_ABS16   = 3'd5,
    EA_PCREL   = 3'd6,
    EA_MEMIND  = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_WAIT = 2'd1,
    FS_DONE = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/ea_arith.sv
module ea_arith
  import ea_pkg::*;
#(
  parameter int unsigned AW = EA_AW,
  parameter int unsigned SW = EA_SW
) (
  input  ea_mode_e        mode,
  input  logic            word_sz,
  input  logic [AW-1:0]   reg_val,
  input  logic [AW-1:0]   ext_word,
  input  logic [AW-1:0]   pc,
  output logic [AW-1:0]   addr,
  output logic [AW-1:0]   wb_val,
  output logic            wb_req,
  output logic            misalign,
  output logic            indirect,
  output logic [AW-1:0]   ind_ptr
);
  localparam int unsigned HW = AW - SW;

  function automatic logic [AW-1:0] f_step(input logic wsz);
    f_step = wsz ? AW'(2) : AW'(1);
  endfunction

  function automatic logic [AW-1:0] f_top_page(input logic [SW-1:0] b);
    f_top_page = {{HW{1'b1}}, b};
  endfunction

  function automatic logic [AW-1:0] f_bottom_page(input logic [SW-1:0] b);
    f_bottom_page = {{HW{1'b0}}, b};
  endfunction

  function automatic logic [AW-1:0] f_branch(input logic [AW-1:0] p,
                                             input logic [SW-1:0] d);
    f_branch = p + {{HW{d[SW-1]}}, d};
  endfunction

  logic [SW-1:0] short_fld;
  logic          need_even;
  logic [AW-1:0] chk_val;

  assign short_fld = ext_word[SW-1:0];
  assign ind_ptr   = f_bottom_page(short_fld);
  assign indirect  = (mode == EA_MEMIND);

  always_comb begin
    addr      = reg_val;
    wb_val    = reg_val;
    wb_req    = 1'b0;
    need_even = word_sz;
    chk_val   = reg_val;
    unique case (mode)
      EA_RIND: begin
        addr    = reg_val;
        chk_val = reg_val;
      end
      EA_DISP: begin
        addr    = reg_val + ext_word;
        chk_val = addr;
      end
      EA_POSTINC: begin
        addr    = reg_val;
        wb_val  = reg_val + f_step(word_sz);
        wb_req  = 1'b1;
        chk_val = reg_val;
      end
      EA_PREDEC: begin
        addr    = reg_val - f_step(word_sz);
        wb_val  = addr;
        wb_req  = 1'b1;
        chk_val = reg_val;
      end
      EA_ABS8: begin
        addr    = f_top_page(short_fld);
        chk_val = addr;
      end
      EA_ABS16: begin
        addr    = ext_word;
        chk_val = addr;
      end
      EA_PCREL: begin
        addr      = f_branch(pc, short_fld);
        need_even = 1'b1;
        chk_val   = addr;
      end
      EA_MEMIND: begin
        addr      = ind_ptr;
        need_even = 1'b1;
        chk_val   = ind_ptr;
      end
      default: begin
        addr = reg_val;
      end
    endcase
  end

  assign misalign = need_even & chk_val[0];
endmodule

// File: rtl/ea_ind_fetch.sv
module ea_ind_fetch
  import ea_pkg::*;
#(
  parameter int unsigned AW = EA_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] ptr,
  output logic          idle,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_rdata,
  output logic          fetch_done,
  output logic [AW-1:0] target
);
  fetch_state_e  st_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] tgt_q;
  logic          beat;

  assign idle       = (st_q == FS_IDLE);
  assign mem_req    = (st_q == FS_WAIT);
  assign mem_addr   = ptr_q;
  assign beat       = mem_req & mem_valid;
  assign fetch_done = (st_q == FS_DONE);
  assign target     = tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      ptr_q <= '0;
      tgt_q <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (launch) begin
          st_q  <= FS_WAIT;
          ptr_q <= ptr;
        end
        FS_WAIT: if (beat) begin
          st_q  <= FS_DONE;
          tgt_q <= mem_rdata;
        end
        FS_DONE: st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
  assert_done_after_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (fetch_done && !mem_req));
  assert_target_is_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (target == $past(mem_rdata)));
  assert_req_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned AW = EA_AW,
  parameter int unsigned SW = EA_SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic          word_sz,
  input  logic [AW-1:0] reg_val,
  input  logic [AW-1:0] ext_word,
  input  logic [AW-1:0] pc,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          fault,
  output logic          reg_we,
  output logic [AW-1:0] reg_wdata
);
  ea_mode_e      mode_e;
  logic [AW-1:0] calc_addr;
  logic [AW-1:0] calc_wb;
  logic          calc_wb_req;
  logic          calc_misalign;
  logic          calc_indirect;
  logic [AW-1:0] calc_ptr;
  logic          f_idle;
  logic          f_done;
  logic [AW-1:0] f_target;
  logic          accept;
  logic          launch;
  logic          quick_done;

  assign mode_e = ea_mode_e'(mode);

  ea_arith #(.AW(AW), .SW(SW)) u_arith (
    .mode     (mode_e),
    .word_sz  (word_sz),
    .reg_val  (reg_val),
    .ext_word (ext_word),
    .pc       (pc),
    .addr     (calc_addr),
    .wb_val   (calc_wb),
    .wb_req   (calc_wb_req),
    .misalign (calc_misalign),
    .indirect (calc_indirect),
    .ind_ptr  (calc_ptr)
  );

  assign accept     = start & f_idle;
  assign launch     = accept & calc_indirect & ~calc_misalign;
  assign quick_done = accept & (~calc_indirect | calc_misalign);

  ea_ind_fetch #(.AW(AW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .ptr        (calc_ptr),
    .idle       (f_idle),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .mem_rdata  (mem_rdata),
    .fetch_done (f_done),
    .target     (f_target)
  );

  assign done      = quick_done | f_done;
  assign ea        = f_done ? f_target : calc_addr;
  assign fault     = quick_done & calc_misalign;
  assign reg_we    = quick_done & calc_wb_req & ~calc_misalign;
  assign reg_wdata = calc_wb;

  assert_we_no_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (done && !fault));
  assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!done && !reg_we));
  assert_odd_ptr_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && f_idle && mode_e == EA_MEMIND && ext_word[0]) |=> !mem_req);
  assert_pcrel_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !f_done && mode_e == EA_PCREL && !fault) |-> !ea[0]);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !f_done) |-> (!done && !fault && !reg_we));
endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        word_sz = 1'b0;
  logic [15:0] reg_val = 16'h0;
  logic [15:0] ext_word = 16'h0;
  logic [15:0] pc = 16'h0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [15:0] mem_rdata = 16'h0;
  logic        done;
  logic [15:0] ea;
  logic        fault;
  logic        reg_we;
  logic [15:0] reg_wdata;

  always #5 clk = ~clk;

  ea_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .word_sz(word_sz),
    .reg_val(reg_val), .ext_word(ext_word), .pc(pc),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .done(done), .ea(ea), .fault(fault),
    .reg_we(reg_we), .reg_wdata(reg_wdata)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  bit    chk_en = 1'b0;
  bit    e_done, e_fault, e_we, e_req;
  int    e_ea, e_wd, e_maddr;
  string tag = "R11";

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (chk_en) begin
      cmp("done", int'(done), int'(e_done));
      cmp("fault", int'(fault), int'(e_fault));
      cmp("reg_we", int'(reg_we), int'(e_we));
      cmp("mem_req", int'(mem_req), int'(e_req));
      if (e_done && !e_fault) cmp("ea", int'(ea), e_ea);
      if (e_we) cmp("reg_wdata", int'(reg_wdata), e_wd);
      if (e_req) cmp("mem_addr", int'(mem_addr), e_maddr);
    end
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic int memword(int a);
    return ((a * 40503) ^ 23130) & 65535;
  endfunction

  task automatic quiet();
    e_done = 0; e_fault = 0; e_we = 0; e_req = 0;
  endtask

  task automatic op(string t, int m, bit w, int r, int x, int p);
    int step, lo, d;
    @(posedge clk); #1;
    tag = t;
    start = 1; mode = 3'(m); word_sz = w;
    reg_val = 16'(r); ext_word = 16'(x); pc = 16'(p);
    quiet();
    e_done = 1;
    step = w ? 2 : 1;
    lo = x & 255;
    case (m)
      0: begin e_ea = r; e_fault = w && (r % 2 == 1); end
      1: begin e_ea = (r + x) & 65535; e_fault = w && (e_ea % 2 == 1); end
      2: begin e_ea = r; e_wd = (r + step) & 65535; e_fault = w && (r % 2 == 1); e_we = !e_fault; end
      3: begin e_ea = (r - step + 65536) & 65535; e_wd = e_ea; e_fault = w && (r % 2 == 1); e_we = !e_fault; end
      4: begin e_ea = 65280 + lo; e_fault = w && (lo % 2 == 1); end
      5: begin e_ea = x; e_fault = w && (x % 2 == 1); end
      6: begin d = (lo > 127) ? lo - 256 : lo; e_ea = (p + d + 65536) & 65535; e_fault = (e_ea % 2 == 1); end
      default: begin e_ea = 0; e_fault = 1; end
    endcase
  endtask

  task automatic mem_ind(int ptr, int lat, bit inject);
    int tgt;
    @(posedge clk); #1;
    tag = (ptr % 2 == 1) ? "R8" : "R7";
    start = 1; mode = 3'd7; word_sz = 1'b0; ext_word = 16'(16'hAB00 | ptr);
    quiet();
    if (ptr % 2 == 1) begin
      e_done = 1; e_fault = 1;
      @(posedge clk); #1; start = 0; quiet();
      return;
    end
    tgt = memword(ptr);
    for (int i = 0; i < lat; i++) begin
      @(posedge clk); #1;
      start = 0; quiet(); e_req = 1; e_maddr = ptr; mem_valid = 0;
      if (inject && i == 0) begin
        tag = "R10"; start = 1; mode = 3'd2; word_sz = 1; reg_val = 16'h0100;
      end else tag = "R7";
    end
    @(posedge clk); #1;
    tag = "R7"; start = 0; quiet(); e_req = 1; e_maddr = ptr;
    mem_valid = 1; mem_rdata = 16'(tgt);
    @(posedge clk); #1;
    mem_valid = 0; mem_rdata = 16'h0; quiet(); e_done = 1; e_ea = tgt;
    if (inject) begin
      tag = "R10"; start = 1; mode = 3'd1; reg_val = 16'h0010; ext_word = 16'h0002;
    end
    @(posedge clk); #1; start = 0; quiet(); tag = "R11";
  endtask

  initial begin
    quiet();
    chk_en = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1 tag = "R11"; quiet();
    op("R1", 0, 0, 16'h1235, 0, 0);
    op("R1", 1, 0, 16'h1000, 16'h0234, 0);
    op("R5", 1, 1, 16'h1000, 16'h0235, 0);
    op("R9", 1, 1, 16'hFFF0, 16'h0020, 0);
    op("R2", 2, 0, 16'h4001, 0, 0);
    op("R2", 2, 1, 16'h4002, 0, 0);
    op("R9", 2, 1, 16'hFFFE, 0, 0);
    op("R3", 3, 0, 16'h4001, 0, 0);
    op("R3", 3, 1, 16'h4002, 0, 0);
    op("R9", 3, 0, 16'h0000, 0, 0);
    op("R4", 2, 1, 16'h4003, 0, 0);
    op("R4", 3, 1, 16'h4003, 0, 0);
    op("R5", 4, 0, 16'h0000, 16'h1281, 0);
    op("R5", 4, 1, 16'h0000, 16'h1281, 0);
    op("R5", 5, 1, 16'h0000, 16'h8642, 0);
    op("R5", 5, 1, 16'h0000, 16'h8643, 0);
    op("R5", 0, 1, 16'h2001, 0, 0);
    op("R6", 6, 0, 0, 16'h0080, 16'h1000);
    op("R6", 6, 1, 0, 16'h007E, 16'h1000);
    op("R6", 6, 0, 0, 16'h0011, 16'h1000);
    op("R9", 6, 0, 0, 16'h00F0, 16'h0004);
    @(posedge clk); #1 start = 0; tag = "R11"; quiet();
    @(posedge clk);
    mem_ind(16'h10, 0, 0);
    mem_ind(16'h22, 3, 0);
    mem_ind(16'h33, 0, 0);
    mem_ind(16'hFE, 4, 1);
    mem_ind(16'h00, 1, 0);
    op("R1", 1, 0, 16'h0100, 16'h0001, 0);
    @(posedge clk); #1 start = 0; tag = "R11"; quiet();
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule